// File: doc/BRIEF.md
# Receive Frame Length Checker

This block sits in an Ethernet receive path after preamble and start-delimiter stripping. It counts every in-frame byte (destination and source addresses, type/length field, payload, pad and FCS) between a frame-start strobe and a frame-end strobe. It judges the count against two 16-bit programmable bounds, an upper length bound and a lower length bound. Typical settings are 1518 and 64.

A down-counter holds the remaining byte budget for the current frame. Once the budget is spent, further bytes are refused through the byte-accept output, so the data path truncates the frame. The frame is still reported with a too-long flag. Frames under the lower bound are marked for discard by default. When the keep-short mode is on, they are kept and flagged too-short instead. One cycle after the frame-end strobe a single-cycle status appears, carrying the flags, the length and the discard indication.

Top module: `rx_len_check`

## Requirements
- R1: While `rst_n` is low and after reset, `byte_acc`, `stat_vld`, `stat_long`, `stat_short` and `stat_drop` are 0 and `stat_len` is 0.
- R2: A byte is counted only when `byte_vld` is high while a frame is open, and not in a cycle that carries `frm_start` or `frm_end`. Bytes outside a frame give `byte_acc` = 0 and do not change the next status.
- R3: `max_len`, `min_len` and `keep_short` are captured in the `frm_start` cycle. Changes to them during a frame have no effect on that frame.
- R4: `byte_acc` is high for the first `max_len` counted bytes of a frame and low for every later byte of the same frame.
- R5: `stat_vld` is high for exactly one cycle, in the cycle after a `frm_end` that closes an open frame. A `frm_end` while no frame is open produces no status.
- R6: `stat_len` (17 bits) equals the number of counted bytes, saturating at the captured maximum plus one.
- R7: `stat_long` is 1 exactly when more bytes than the captured maximum arrived. An oversized frame is never marked for discard by its length.
- R8: `stat_short` is 1 when the frame is not too long and `stat_len` is below the captured minimum. With keep-short off, `stat_drop` equals `stat_short`.
- R9: With keep-short on, a short frame has `stat_short` = 1 and `stat_drop` = 0.
- R10: A `frm_start` while a frame is open abandons it without a status. The new frame counts from zero with freshly captured limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frm_start | input | 1 | Frame opens after the start delimiter (no byte in this cycle) |
| frm_end | input | 1 | Frame closes (no byte counted in this cycle) |
| byte_vld | input | 1 | One received byte present |
| max_len | input | 16 | Upper length bound, captured at frame start |
| min_len | input | 16 | Lower length bound, captured at frame start |
| keep_short | input | 1 | 1: keep and flag short frames; 0: mark them for discard |
| byte_acc | output | 1 | Current byte is accepted into the frame |
| stat_vld | output | 1 | Status valid, one cycle |
| stat_long | output | 1 | Frame exceeded the upper bound |
| stat_short | output | 1 | Frame below the lower bound |
| stat_drop | output | 1 | Frame is to be discarded |
| stat_len | output | 17 | Final frame length, saturating at maximum plus one |

## Verification
The assertions check every cycle that accepted bytes never exceed the captured bound, that a status lasts one cycle and follows a frame end, that the two flags never appear together, that a discard implies a short flag, and that a too-long status carries the saturated length. Only the bench scenarios can show the exact lengths and flag values for given byte counts. These include the boundaries at exactly the minimum and exactly the maximum, a zero bound, and a long frame with realistic limits. The bench scenarios also cover limit changes in mid-frame, restarts and stray end strobes.

// File: rtl/rx_len_pkg.sv
// Shared definitions for the receive frame length checker.
// Assumes: nothing beyond standard SystemVerilog.
package rx_len_pkg;

    // Frame tracking state of the checker.
    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_OPEN = 1'b1
    } frame_state_e;

endpackage

// File: rtl/rx_len_budget.sv
// Byte budget: captures the limits and the mode at frame start and holds a
// down-counter of the bytes still allowed in the current frame.
// Assumes: load and take are never high together (the top enforces this).
module rx_len_budget #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             take,
    input  logic [LEN_W-1:0] max_in,
    input  logic [LEN_W-1:0] min_in,
    input  logic             keep_in,
    output logic             room,
    output logic [LEN_W-1:0] max_q,
    output logic [LEN_W-1:0] min_q,
    output logic             keep_q
);
    logic [LEN_W-1:0] left_q;

    // Capture the limits and the mode at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_q  <= '0;
            min_q  <= '0;
            keep_q <= 1'b0;
        end else if (load) begin
            max_q  <= max_in;
            min_q  <= min_in;
            keep_q <= keep_in;
        end
    end

    // Remaining-bytes down-counter, reloaded at start, decremented per accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= max_in;
        end else if (take && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    // Budget is open while the counter is non-zero.
    always_comb room = (left_q != '0);

endmodule

// File: rtl/rx_len_tally.sv
// Length tally: counts in-frame bytes and saturates at a given cap.
// Assumes: cap is stable during a frame (it derives from captured limits).
module rx_len_tally #(
    parameter int LEN_W = 16,
    localparam int CW   = LEN_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          bump,
    input  logic [CW-1:0] cap,
    output logic [CW-1:0] len
);
    // Count bytes; hold once the cap has been reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len <= '0;
        end else if (clear) begin
            len <= '0;
        end else if (bump && len != cap) begin
            len <= len + 1'b1;
        end
    end

endmodule

// File: rtl/rx_len_judge.sv
// Status stage: on frame close, registers the length and the too-long,
// too-short and discard decisions, valid for a single cycle.
// Assumes: len never exceeds cap, so len == cap means the bound was overrun.
module rx_len_judge #(
    parameter int LEN_W = 16,
    localparam int CW   = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             close,
    input  logic [CW-1:0]    len,
    input  logic [CW-1:0]    cap,
    input  logic [LEN_W-1:0] min_q,
    input  logic             keep_q,
    output logic             vld,
    output logic             long_f,
    output logic             short_f,
    output logic             drop,
    output logic [CW-1:0]    len_o
);
    logic over_c;
    logic under_c;

    // Classify the closing frame.
    always_comb begin
        over_c  = (len == cap);
        under_c = !over_c && (len < {1'b0, min_q});
    end

    // Register the status for one cycle; fields hold until the next close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld     <= 1'b0;
            long_f  <= 1'b0;
            short_f <= 1'b0;
            drop    <= 1'b0;
            len_o   <= '0;
        end else begin
            vld <= close;
            if (close) begin
                long_f  <= over_c;
                short_f <= under_c;
                drop    <= under_c && !keep_q;
                len_o   <= len;
            end
        end
    end

endmodule

// File: rtl/rx_len_check.sv
// Receive frame length checker top: tracks the open frame, steers bytes to
// the budget and tally, and closes the frame into the status stage.
// Assumes: frm_start and frm_end cycles carry no counted byte; a start while
// open restarts the frame; a start wins over a simultaneous end.
module rx_len_check #(
    parameter int LEN_W = 16,
    localparam int CW   = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_start,
    input  logic             frm_end,
    input  logic             byte_vld,
    input  logic [LEN_W-1:0] max_len,
    input  logic [LEN_W-1:0] min_len,
    input  logic             keep_short,
    output logic             byte_acc,
    output logic             stat_vld,
    output logic             stat_long,
    output logic             stat_short,
    output logic             stat_drop,
    output logic [CW-1:0]    stat_len
);
    import rx_len_pkg::*;

    frame_state_e     fs_q;
    logic             take_c;
    logic             close_c;
    logic             room;
    logic [LEN_W-1:0] max_q;
    logic [LEN_W-1:0] min_q;
    logic             keep_q;
    logic [CW-1:0]    cap_c;
    logic [CW-1:0]    len_q;

    // Frame open/closed tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q <= FS_IDLE;
        end else if (frm_start) begin
            fs_q <= FS_OPEN;
        end else if (frm_end) begin
            fs_q <= FS_IDLE;
        end
    end

    // Byte steering, frame close and saturation cap.
    always_comb begin
        take_c   = (fs_q == FS_OPEN) && byte_vld && !frm_start && !frm_end;
        close_c  = (fs_q == FS_OPEN) && frm_end && !frm_start;
        byte_acc = take_c && room;
        cap_c    = {1'b0, max_q} + 1'b1;
    end

    rx_len_budget #(.LEN_W(LEN_W)) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (frm_start),
        .take    (byte_acc),
        .max_in  (max_len),
        .min_in  (min_len),
        .keep_in (keep_short),
        .room    (room),
        .max_q   (max_q),
        .min_q   (min_q),
        .keep_q  (keep_q)
    );

    rx_len_tally #(.LEN_W(LEN_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (frm_start),
        .bump  (take_c),
        .cap   (cap_c),
        .len   (len_q)
    );

    rx_len_judge #(.LEN_W(LEN_W)) u_judge (
        .clk     (clk),
        .rst_n   (rst_n),
        .close   (close_c),
        .len     (len_q),
        .cap     (cap_c),
        .min_q   (min_q),
        .keep_q  (keep_q),
        .vld     (stat_vld),
        .long_f  (stat_long),
        .short_f (stat_short),
        .drop    (stat_drop),
        .len_o   (stat_len)
    );

endmodule

// File: rtl/rx_len_check_sva.sv
// Port-level checker for rx_len_check, bound to every instance of it.
// Keeps its own copy of the bound and its own accepted-byte count.
module rx_len_check_sva #(
    parameter int LEN_W = 16,
    localparam int CW   = LEN_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frm_start,
    input logic             frm_end,
    input logic             byte_vld,
    input logic [LEN_W-1:0] max_len,
    input logic             byte_acc,
    input logic             stat_vld,
    input logic             stat_long,
    input logic             stat_short,
    input logic             stat_drop,
    input logic [CW-1:0]    stat_len
);
    logic [CW-1:0] bound_q;
    logic [CW-1:0] acc_n_q;

    // Track the bound in force and the accepted bytes of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bound_q <= '0;
            acc_n_q <= '0;
        end else if (frm_start) begin
            bound_q <= {1'b0, max_len};
            acc_n_q <= '0;
        end else if (byte_acc) begin
            acc_n_q <= acc_n_q + 1'b1;
        end
    end

    a_r2_acc_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        byte_acc |-> (byte_vld && !frm_start && !frm_end));

    a_r4_acc_within_bound: assert property (@(posedge clk) disable iff (!rst_n)
        byte_acc |-> (acc_n_q < bound_q));

    a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |=> !stat_vld);

    a_r5_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_vld) |-> $past(frm_end));

    a_r6_len_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> (stat_len <= bound_q + 1'b1));

    a_r7_long_len: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vld && stat_long) |-> (stat_len == bound_q + 1'b1));

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> !(stat_long && stat_short));

    a_r8_drop_needs_short: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vld && stat_drop) |-> stat_short);

endmodule

bind rx_len_check rx_len_check_sva #(.LEN_W(LEN_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_start  (frm_start),
    .frm_end    (frm_end),
    .byte_vld   (byte_vld),
    .max_len    (max_len),
    .byte_acc   (byte_acc),
    .stat_vld   (stat_vld),
    .stat_long  (stat_long),
    .stat_short (stat_short),
    .stat_drop  (stat_drop),
    .stat_len   (stat_len)
);

// File: tb/sim_rx_len_check.sv
`timescale 1ns/1ps
module sim_rx_len_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_start = 1'b0;
    logic        frm_end = 1'b0;
    logic        byte_vld = 1'b0;
    logic [15:0] max_len = '0;
    logic [15:0] min_len = '0;
    logic        keep_short = 1'b0;
    logic        byte_acc;
    logic        stat_vld;
    logic        stat_long;
    logic        stat_short;
    logic        stat_drop;
    logic [16:0] stat_len;

    int n_run = 0;
    int n_bad = 0;
    int acc_seen;
    int cyc = 0;

    always #2.5 clk = ~clk;

    rx_len_check u0 (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
        .byte_vld(byte_vld), .max_len(max_len), .min_len(min_len),
        .keep_short(keep_short), .byte_acc(byte_acc), .stat_vld(stat_vld),
        .stat_long(stat_long), .stat_short(stat_short), .stat_drop(stat_drop),
        .stat_len(stat_len)
    );

    typedef struct packed {
        logic [15:0] mx;
        logic [15:0] mn;
        logic        keep;
        logic [15:0] nb;
        logic [16:0] e_len;
        logic        e_long;
        logic        e_short;
        logic        e_drop;
        logic [15:0] e_acc;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{16'd20,   16'd8,  1'b0, 16'd12,   17'd12,   1'b0, 1'b0, 1'b0, 16'd12},
        '{16'd20,   16'd8,  1'b0, 16'd20,   17'd20,   1'b0, 1'b0, 1'b0, 16'd20},
        '{16'd20,   16'd8,  1'b0, 16'd21,   17'd21,   1'b1, 1'b0, 1'b0, 16'd20},
        '{16'd20,   16'd8,  1'b0, 16'd30,   17'd21,   1'b1, 1'b0, 1'b0, 16'd20},
        '{16'd20,   16'd8,  1'b0, 16'd5,    17'd5,    1'b0, 1'b1, 1'b1, 16'd5},
        '{16'd20,   16'd8,  1'b1, 16'd5,    17'd5,    1'b0, 1'b1, 1'b0, 16'd5},
        '{16'd20,   16'd8,  1'b0, 16'd8,    17'd8,    1'b0, 1'b0, 1'b0, 16'd8},
        '{16'd20,   16'd8,  1'b0, 16'd0,    17'd0,    1'b0, 1'b1, 1'b1, 16'd0},
        '{16'd0,    16'd0,  1'b0, 16'd3,    17'd1,    1'b1, 1'b0, 1'b0, 16'd0},
        '{16'd1518, 16'd64, 1'b0, 16'd64,   17'd64,   1'b0, 1'b0, 1'b0, 16'd64},
        '{16'd1518, 16'd64, 1'b0, 16'd1530, 17'd1519, 1'b1, 1'b0, 1'b0, 16'd1518}
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Open a frame, send nb bytes, close it; counts byte_acc highs.
    task automatic send_frame(input logic [15:0] mx, input logic [15:0] mn,
                              input logic kp, input int nb);
        @(negedge clk);
        max_len = mx; min_len = mn; keep_short = kp; frm_start = 1'b1;
        @(negedge clk);
        frm_start = 1'b0;
        acc_seen = 0;
        for (int i = 0; i < nb; i++) begin
            byte_vld = 1'b1;
            #1;
            if (byte_acc) acc_seen++;
            @(negedge clk);
        end
        byte_vld = 1'b0;
        frm_end = 1'b1;
        @(negedge clk);
        frm_end = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_run++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!byte_acc && !stat_vld && !stat_long && !stat_short && !stat_drop,
              "R1 flags in reset", 1, 0);
        check(stat_len == 0, "R1 len in reset", int'(stat_len), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!stat_vld && !byte_acc, "R1 after reset", int'(stat_vld), 0);

        // Table walk: R4 R6 R7 R8 R9
        for (int k = 0; k < NV; k++) begin
            send_frame(TBL[k].mx, TBL[k].mn, TBL[k].keep, int'(TBL[k].nb));
            check(stat_vld, "R5 status valid", int'(stat_vld), 1);
            check(stat_len == TBL[k].e_len, "R6 length", int'(stat_len), int'(TBL[k].e_len));
            check(stat_long == TBL[k].e_long, "R7 long flag", int'(stat_long), int'(TBL[k].e_long));
            check(stat_short == TBL[k].e_short, "R8 short flag", int'(stat_short), int'(TBL[k].e_short));
            check(stat_drop == TBL[k].e_drop, "R8/R9 drop", int'(stat_drop), int'(TBL[k].e_drop));
            check(acc_seen == int'(TBL[k].e_acc), "R4 accepted bytes", acc_seen, int'(TBL[k].e_acc));
            @(negedge clk);
            check(!stat_vld, "R5 one cycle", int'(stat_vld), 0);
        end

        // R5: frame end while idle gives no status
        @(negedge clk); frm_end = 1'b1;
        @(negedge clk); frm_end = 1'b0;
        check(!stat_vld, "R5 stray end", int'(stat_vld), 0);

        // R2: bytes outside a frame are not accepted nor counted
        byte_vld = 1'b1; #1;
        check(!byte_acc, "R2 idle byte", int'(byte_acc), 0);
        repeat (4) @(negedge clk);
        byte_vld = 1'b0;
        send_frame(16'd20, 16'd0, 1'b0, 3);
        check(stat_len == 3, "R2 idle bytes not counted", int'(stat_len), 3);

        // R3: limits changed mid-frame have no effect
        @(negedge clk);
        max_len = 16'd4; min_len = 16'd2; keep_short = 1'b0; frm_start = 1'b1;
        @(negedge clk);
        frm_start = 1'b0; max_len = 16'd100; min_len = 16'd50; keep_short = 1'b1;
        acc_seen = 0;
        for (int i = 0; i < 6; i++) begin
            byte_vld = 1'b1; #1;
            if (byte_acc) acc_seen++;
            @(negedge clk);
        end
        byte_vld = 1'b0; frm_end = 1'b1;
        @(negedge clk); frm_end = 1'b0;
        check(acc_seen == 4, "R3 captured max", acc_seen, 4);
        check(stat_long && stat_len == 5, "R3 captured max len", int'(stat_len), 5);

        @(negedge clk);
        max_len = 16'd20; min_len = 16'd10; keep_short = 1'b0; frm_start = 1'b1;
        @(negedge clk);
        frm_start = 1'b0; keep_short = 1'b1;
        byte_vld = 1'b1; @(negedge clk); byte_vld = 1'b0;
        frm_end = 1'b1; @(negedge clk); frm_end = 1'b0;
        check(stat_short && stat_drop, "R3 captured keep mode", int'(stat_drop), 1);

        // R10: restart mid-frame abandons the open frame
        @(negedge clk);
        max_len = 16'd20; min_len = 16'd0; keep_short = 1'b0; frm_start = 1'b1;
        @(negedge clk); frm_start = 1'b0;
        byte_vld = 1'b1; repeat (5) @(negedge clk); byte_vld = 1'b0;
        frm_start = 1'b1;
        @(negedge clk); frm_start = 1'b0;
        check(!stat_vld, "R10 no status on restart", int'(stat_vld), 0);
        byte_vld = 1'b1; repeat (3) @(negedge clk); byte_vld = 1'b0;
        frm_end = 1'b1; @(negedge clk); frm_end = 1'b0;
        check(stat_vld && stat_len == 3, "R10 restarted length", int'(stat_len), 3);

        // R1: reset mid-frame returns outputs to idle
        @(negedge clk); frm_start = 1'b1;
        @(negedge clk); frm_start = 1'b0; byte_vld = 1'b1;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check(!byte_acc && stat_len == 0, "R1 reset mid-frame", int'(byte_acc), 0);
        byte_vld = 1'b0;

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule